// File: doc/BRIEF.md
# Receiver AGC Window Controller

This block is the digital decision logic of a receiver automatic gain control loop. On every subcarrier pulse strobe it looks at one of two comparator inputs, which tell whether the demodulated amplitude is above three times or above five times the digitizing level. If the selected comparator is high and gain control is enabled, it raises a 2-bit gain-reduction code by one step. The code saturates at its top value. The analog gain stages and filters that act on the code are outside this block.

By default, gain decisions are allowed only during the first few subcarrier pulses of each received packet. After that, the decision is frozen and a frozen flag is raised, so the gain stays constant for the rest of the data. A no-limit setting removes this freeze. A start-of-receive strobe opens a new window: it clears the pulse count and the frozen flag. The gain code keeps its last value across packets, so it can only be raised further.

An 8-bit settings word holds the enable, the threshold select, the no-limit bit and a manual reduction floor. The gain-reduction output is the larger of the manual floor and the code the loop has built up. A write to the protocol-select register presets the settings word to its default value.

Top module: `agc_window_ctrl`

## Requirements
- R1: After synchronous reset, `gain_code` is 0 and `frozen` is 0. The settings word holds its default 0x40: enabled, five-times threshold, limited window, manual floor 0.
- R2: A pulse on `sc_pulse` steps the internal reduction code up by one, visible on `gain_code` after the next rising edge, when all of these hold:
  - gain control is enabled;
  - the window is open;
  - the selected comparator is high.
  The code saturates at 3.
- R3: Settings bit 2 selects the comparator. 1 selects `over_3x`; 0 selects `over_5x`. The comparator that is not selected has no effect.
- R4: When settings bit 6 (enable) is 0, no pulse changes the reduction code.
- R5: After WINDOW_PULSES pulses counted since the last start of receive, `frozen` is 1. Further pulses do not change the code. The pulse that reaches the limit can still step.
- R6: When settings bit 3 (no-limit) is 1, `frozen` stays 0 and pulses may step the code at any count.
- R7: `rx_start` clears the pulse count and `frozen` at the next edge and keeps the reduction code. A pulse in the same cycle as `rx_start` is neither counted nor acted on.
- R8: `gain_code` is the larger of the internal reduction code and the manual floor in settings bits [1:0]. The floor values 0, 1, 2 and 3 stand for 0, 5, 10 and 15 dB.
- R9: `proto_wr` presets the settings word to 0x40 and takes priority over a simultaneous `cfg_wr`. A `cfg_wr` alone loads `cfg_wdata`. Neither one changes the reduction code.
- R10: Comparator activity without `sc_pulse` changes neither the code nor the pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sc_pulse | input | 1 | One-cycle subcarrier pulse strobe |
| over_3x | input | 1 | Amplitude above three times the digitizing level |
| over_5x | input | 1 | Amplitude above five times the digitizing level |
| rx_start | input | 1 | Start-of-receive strobe |
| cfg_wr | input | 1 | Load the settings word from cfg_wdata |
| cfg_wdata | input | 8 | Settings word: [6] enable, [3] no-limit, [2] 3x select, [1:0] manual floor |
| proto_wr | input | 1 | Protocol-select write; presets the settings word to 0x40 |
| gain_code | output | 2 | Gain-reduction code applied to the receiver |
| frozen | output | 1 | Decision window closed for this packet |

## Verification
Each stimulus is one clock cycle of input, and every result appears right after the next rising edge. This covers a code step, a pulse count, a window freeze, a clear on start of receive and a settings write. No result appears later than that. The bench therefore drives inputs on the falling edge and checks `gain_code` and `frozen` on the following falling edge, one full edge later. A step decision uses the settings word as it stood before a write in the same cycle, and the bench model follows that same order.

// File: rtl/agcw_pkg.sv
package agcw_pkg;

    localparam int SET_W  = 8;
    localparam int GAIN_W = 2;
    localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

    typedef struct packed {
        logic              rsv7;
        logic              enable;
        logic [1:0]        rsv54;
        logic              no_limit;
        logic              sel_3x;
        logic [GAIN_W-1:0] floor_code;
    } agc_set_t;

    localparam agc_set_t SET_DEFAULT = agc_set_t'(8'h40);

    function automatic logic [GAIN_W-1:0] larger(input logic [GAIN_W-1:0] a,
                                                 input logic [GAIN_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [GAIN_W-1:0] sat_inc(input logic [GAIN_W-1:0] v);
        return (v == GAIN_MAX) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/agcw_settings.sv
module agcw_settings
    import agcw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [SET_W-1:0] cfg_wdata,
    input  logic             proto_wr,
    output agc_set_t         set_q
);

    always_ff @(posedge clk) begin
        if (rst || proto_wr) set_q <= SET_DEFAULT;
        else if (cfg_wr)     set_q <= agc_set_t'(cfg_wdata);
    end

    // R9: a protocol-select write leaves the default word in place
    p_preset_r9: assert property (@(posedge clk) disable iff (rst)
        proto_wr |=> (set_q == SET_DEFAULT));

endmodule

// File: rtl/agcw_window.sv
module agcw_window #(
    parameter int WINDOW_PULSES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sc_pulse,
    input  logic rx_start,
    input  logic no_limit,
    output logic win_open,
    output logic frozen
);

    localparam int CNT_W = $clog2(WINDOW_PULSES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW_PULSES);

    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == LIMIT);
    assign win_open = !at_limit || no_limit;
    assign frozen   = at_limit && !no_limit;

    always_ff @(posedge clk) begin
        if (rst || rx_start)           cnt_q <= '0;
        else if (sc_pulse && !at_limit) cnt_q <= cnt_q + 1'b1;
    end

    // R7: a start of receive reopens the window
    p_rx_clear_r7: assert property (@(posedge clk) disable iff (rst)
        rx_start |=> (cnt_q == '0));

    // R10: the count moves only on a pulse
    p_cnt_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!sc_pulse && !rx_start) |=> $stable(cnt_q));

    // R5: once at the limit the count holds until the next start
    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (at_limit && !rx_start) |=> $stable(cnt_q));

endmodule

// File: rtl/agcw_gain.sv
module agcw_gain
    import agcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sc_pulse,
    input  logic              rx_start,
    input  logic              over_3x,
    input  logic              over_5x,
    input  agc_set_t          set_q,
    input  logic              win_open,
    output logic [GAIN_W-1:0] gain_code
);

    logic [GAIN_W-1:0] agc_q;
    logic              over_sel;
    logic              step;

    assign over_sel  = set_q.sel_3x ? over_3x : over_5x;
    assign step      = sc_pulse && !rx_start && set_q.enable && win_open && over_sel;
    assign gain_code = larger(agc_q, set_q.floor_code);

    always_ff @(posedge clk) begin
        if (rst)       agc_q <= '0;
        else if (step) agc_q <= sat_inc(agc_q);
    end

    // R2: the code moves by at most one step per cycle and never downward
    p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (agc_q == $past(agc_q)) || (agc_q == $past(agc_q) + 1'b1));

    // R4: a disabled loop holds its code
    p_disabled_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !set_q.enable |=> $stable(agc_q));

    // R10: without a pulse the code holds
    p_no_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        !sc_pulse |=> $stable(agc_q));

endmodule

// File: rtl/agc_window_ctrl.sv
module agc_window_ctrl
    import agcw_pkg::*;
#(
    parameter int WINDOW_PULSES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sc_pulse,
    input  logic              over_3x,
    input  logic              over_5x,
    input  logic              rx_start,
    input  logic              cfg_wr,
    input  logic [SET_W-1:0]  cfg_wdata,
    input  logic              proto_wr,
    output logic [GAIN_W-1:0] gain_code,
    output logic              frozen
);

    agc_set_t set_q;
    logic     win_open;

    agcw_settings u_settings (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .proto_wr  (proto_wr),
        .set_q     (set_q)
    );

    agcw_window #(.WINDOW_PULSES(WINDOW_PULSES)) u_window (
        .clk      (clk),
        .rst      (rst),
        .sc_pulse (sc_pulse),
        .rx_start (rx_start),
        .no_limit (set_q.no_limit),
        .win_open (win_open),
        .frozen   (frozen)
    );

    agcw_gain u_gain (
        .clk       (clk),
        .rst       (rst),
        .sc_pulse  (sc_pulse),
        .rx_start  (rx_start),
        .over_3x   (over_3x),
        .over_5x   (over_5x),
        .set_q     (set_q),
        .win_open  (win_open),
        .gain_code (gain_code)
    );

    // R8: the applied reduction never drops below the manual floor
    p_floor_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (gain_code >= set_q.floor_code));

    // R7: the frozen flag is gone right after a start of receive
    p_unfreeze_r7: assert property (@(posedge clk) disable iff (rst)
        rx_start |=> !frozen);

endmodule

// File: tb/test_agc_window_ctrl.sv
module test_agc_window_ctrl;

    localparam int W = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sc_pulse = 1'b0, over_3x = 1'b0, over_5x = 1'b0, rx_start = 1'b0;
    logic       cfg_wr = 1'b0, proto_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [1:0] gain_code;
    logic       frozen;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [7:0] m_cfg;
    int         m_agc, m_cnt;

    always #2 clk = ~clk;

    agc_window_ctrl #(.WINDOW_PULSES(W)) i_agc_window_ctrl (
        .clk(clk), .rst(rst), .sc_pulse(sc_pulse), .over_3x(over_3x),
        .over_5x(over_5x), .rx_start(rx_start), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .proto_wr(proto_wr),
        .gain_code(gain_code), .frozen(frozen)
    );

    task automatic check(input string req, input int gexp, input bit fexp);
        checks++;
        if (gain_code !== 2'(gexp) || frozen !== fexp) begin
            errors++;
            $display("FAIL %s: gain=%0d frozen=%0b expected gain=%0d frozen=%0b",
                     req, gain_code, frozen, gexp, fexp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {sc_pulse, over_3x, over_5x, rx_start, cfg_wr, proto_wr} = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_cfg = 8'h40; m_agc = 0; m_cnt = 0;
        check("R1", 0, 0);
    endtask

    task automatic drive(input bit p, input bit o3, input bit o5, input bit rs,
                         input bit wr, input logic [7:0] wd, input bit pw,
                         input string req);
        bit sel, open;
        sc_pulse = p; over_3x = o3; over_5x = o5; rx_start = rs;
        cfg_wr = wr; cfg_wdata = wd; proto_wr = pw;
        if (rs) m_cnt = 0;
        else if (p) begin
            sel  = m_cfg[2] ? o3 : o5;
            open = (m_cnt < W) || m_cfg[3];
            if (m_cfg[6] && open && sel && m_agc < 3) m_agc++;
            if (m_cnt < W) m_cnt++;
        end
        if (pw) m_cfg = 8'h40;
        else if (wr) m_cfg = wd;
        @(posedge clk); @(negedge clk);
        {sc_pulse, over_3x, over_5x, rx_start, cfg_wr, proto_wr} = '0;
        check(req, (m_agc > int'(m_cfg[1:0])) ? m_agc : int'(m_cfg[1:0]),
              (m_cnt >= W) && !m_cfg[3]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: default word steps on the five-times comparator
        do_reset();
        drive(1, 1, 0, 0, 0, 8'h00, 0, "R1 3x ignored by default");
        drive(1, 0, 1, 0, 0, 8'h00, 0, "R1 default enabled");

        // Sweep: enable x threshold x no-limit x floor x comparator pattern
        for (int c = 0; c < 32; c++) begin
            for (int pat = 0; pat < 4; pat++) begin
                logic [7:0] wv;
                wv = {1'b0, c[4], 2'b00, c[3], c[2], c[1:0]};
                do_reset();
                drive(0, 0, 0, 0, 1, wv, 0, "R8 floor after write");
                drive(0, 0, 0, 1, 0, 8'h00, 0, "R7 start");
                for (int k = 0; k < 7; k++)
                    drive(1, pat[0], pat[1], 0, 0, 8'h00, 0, "R2 R3 R4 R5 R6 pulse");
                drive(0, 1, 1, 0, 0, 8'h00, 0, "R10 no pulse");
                drive(0, 0, 0, 1, 0, 8'h00, 0, "R7 code kept");
                drive(1, pat[0], pat[1], 0, 0, 8'h00, 0, "R5 new window");
            end
        end

        // R7: pulse in same cycle as start is dropped
        do_reset();
        drive(1, 0, 1, 1, 0, 8'h00, 0, "R7 pulse with start");
        drive(1, 0, 1, 0, 0, 8'h00, 0, "R7 first counted pulse");

        // R9: preset wins over write; code is kept
        do_reset();
        drive(1, 0, 1, 0, 0, 8'h00, 0, "R2 step");
        drive(0, 0, 0, 0, 1, 8'h4F, 0, "R9 write floor 3 no-limit 3x");
        drive(0, 0, 0, 0, 1, 8'h07, 1, "R9 preset over write");
        drive(1, 1, 0, 0, 0, 8'h00, 0, "R9 back to 5x");
        drive(1, 0, 1, 0, 0, 8'h00, 0, "R9 enabled again");

        // R2: saturation with no-limit
        do_reset();
        drive(0, 0, 0, 0, 1, 8'h48, 0, "R6 no-limit");
        for (int k = 0; k < 10; k++)
            drive(1, 0, 1, 0, 0, 8'h00, 0, "R2 saturate");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule